// File: doc/BRIEF.md
# Debug Event Comparator Array

This block watches the processor's debug event stream and reports, for each of eight independent comparators, whether the current event meets that comparator's programmed condition. Each comparator has a control register and a 32-bit reference value. The control register chooses which kinds of event the comparator looks at, how it compares, and whether the comparison is signed. The comparator then tests the event's 32-bit value against its reference. Software or a debug host loads the registers through a single write port.

Each event arrives as a strobe, a kind code and a 32-bit value. One clock later the block presents an 8-bit flag vector, one bit per comparator, and a flag that is set when any comparator fired. Logic that chains comparators, counts hits or raises breakpoints consumes these flags; that logic lies outside this block.

Control register layout, 8 bits with the upper write bits dropped:
- bit 0 enables the comparator.
- bits 3:1 pick the condition: 0 none, 1 equal, 2 less, 3 less-or-equal, 4 greater, 5 greater-or-equal, 6 not equal, 7 masked.
- bit 4 selects signed ordering.
- bits 7:5 pick the event filter: 0 never, 1 fetch address, 2 load address, 3 store address, 4 load data, 5 store data, 6 load or store address, 7 load or store data.

Event kind codes: 1 fetch address, 2 load address, 3 store address, 4 load data, 5 store data. Codes 0, 6 and 7 match no filter.

Top module: `dbgmp_array`

## Requirements
- R1: After reset, and again after any later reset, both outputs are zero and every control and reference register holds zero, so no comparator fires until it is programmed again.
- R2: A comparator whose control bit 0 is clear never fires, whatever its other fields and the event hold.
- R3: Filter codes 1 to 5 accept only the single event kind of the same code (1 fetch address, 2 load address, 3 store address, 4 load data, 5 store data).
- R4: Filter code 6 accepts kinds 2 and 3, filter code 7 accepts kinds 4 and 5, and filter code 0 accepts no kind.
- R5: Condition 1 fires when the event value equals the reference, and condition 6 fires when the two differ.
- R6: When control bit 4 is clear, conditions 2, 3, 4 and 5 (less, less-or-equal, greater, greater-or-equal of event value against reference) use unsigned ordering.
- R7: When control bit 4 is set, conditions 2 to 5 use two's-complement ordering.
- R8: Condition 7 fires when the bitwise AND of the event value and the reference is nonzero.
- R9: Condition 0 never fires.
- R10: The flags for an event appear on the clock edge after the edge that samples the event strobe. In a cycle that follows no valid event, the flag vector is zero.
- R11: The any-match output is set exactly when at least one bit of the flag vector is set.
- R12: A register write selects one comparator by index (wr_sel 0 for control, 1 for reference). It affects only that comparator, and it applies to events sampled from the next edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 3 | Event kind code |
| ev_value | input | 32 | Event address or data value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the reference register |
| wr_idx | input | 3 | Comparator index for the write |
| wr_data | input | 32 | Write data; control keeps bits 7:0 |
| match_o | output | 8 | Per-comparator flags for the previous cycle's event |
| any_match_o | output | 1 | OR of the flags |

## Verification
The properties assume the event strobe and the write port are both known (never X) at every sampled edge once reset is released, and that the kind code and value are stable around that edge. The bench meets this by driving every input on the falling edge with defined values, and it drives the strobe low whenever no event is intended. The gating properties relate each flag to what the comparator saw one cycle earlier (the enable bit, the filter result and the empty condition), so they rely on the registers not changing between the sampled event and the flag. The bench therefore never writes a register in the same cycle as an event.

// File: rtl/dbgmp_pkg.sv
package dbgmp_pkg;

  localparam int unsigned MP_COUNT = 8;
  localparam int unsigned VAL_W    = 32;
  localparam int unsigned CTL_W    = 8;
  localparam int unsigned KIND_W   = 3;

  typedef enum logic [KIND_W-1:0] {
    EV_NONE   = 3'd0,
    EV_IFETCH = 3'd1,
    EV_LDADDR = 3'd2,
    EV_STADDR = 3'd3,
    EV_LDDATA = 3'd4,
    EV_STDATA = 3'd5
  } ev_kind_e;

  typedef enum logic [2:0] {
    FLT_NEVER  = 3'd0,
    FLT_IFETCH = 3'd1,
    FLT_LDADDR = 3'd2,
    FLT_STADDR = 3'd3,
    FLT_LDDATA = 3'd4,
    FLT_STDATA = 3'd5,
    FLT_LSADDR = 3'd6,
    FLT_LSDATA = 3'd7
  } filter_e;

  typedef enum logic [2:0] {
    CMP_NONE = 3'd0,
    CMP_EQ   = 3'd1,
    CMP_LT   = 3'd2,
    CMP_LE   = 3'd3,
    CMP_GT   = 3'd4,
    CMP_GE   = 3'd5,
    CMP_NE   = 3'd6,
    CMP_MASK = 3'd7
  } cmp_e;

  typedef struct packed {
    logic [2:0] filter;
    logic       is_signed;
    logic [2:0] cond;
    logic       enable;
  } mp_ctl_t;

  function automatic logic filter_accepts(input logic [2:0] flt,
                                          input logic [KIND_W-1:0] kind);
    logic ok;
    ok = 1'b0;
    case (flt)
      FLT_IFETCH: ok = (kind == EV_IFETCH);
      FLT_LDADDR: ok = (kind == EV_LDADDR);
      FLT_STADDR: ok = (kind == EV_STADDR);
      FLT_LDDATA: ok = (kind == EV_LDDATA);
      FLT_STDATA: ok = (kind == EV_STDATA);
      FLT_LSADDR: ok = (kind == EV_LDADDR) || (kind == EV_STADDR);
      FLT_LSDATA: ok = (kind == EV_LDDATA) || (kind == EV_STDATA);
      default:    ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic value_less(input logic sgn,
                                      input logic [VAL_W-1:0] a,
                                      input logic [VAL_W-1:0] b);
    logic [VAL_W:0] ea;
    logic [VAL_W:0] eb;
    ea = {sgn & a[VAL_W-1], a};
    eb = {sgn & b[VAL_W-1], b};
    return $signed(ea) < $signed(eb);
  endfunction

  function automatic logic cond_holds(input logic [2:0] cond,
                                      input logic sgn,
                                      input logic [VAL_W-1:0] a,
                                      input logic [VAL_W-1:0] b);
    logic eq;
    logic lt;
    logic res;
    eq  = (a == b);
    lt  = value_less(sgn, a, b);
    res = 1'b0;
    case (cond)
      CMP_EQ:   res = eq;
      CMP_NE:   res = !eq;
      CMP_LT:   res = lt;
      CMP_LE:   res = lt || eq;
      CMP_GT:   res = !lt && !eq;
      CMP_GE:   res = !lt;
      CMP_MASK: res = |(a & b);
      default:  res = 1'b0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/dbgmp_regfile.sv
module dbgmp_regfile
  import dbgmp_pkg::*;
#(
  parameter int unsigned NUM_MP = MP_COUNT,
  parameter int unsigned DATA_W = VAL_W,
  parameter int unsigned CW     = CTL_W,
  localparam int unsigned IDX_W = (NUM_MP > 1) ? $clog2(NUM_MP) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         wr_sel,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NUM_MP-1:0][CW-1:0]    ctl_q,
  output logic [NUM_MP-1:0][DATA_W-1:0] ref_q
);

  for (genvar g = 0; g < NUM_MP; g++) begin : g_slot
    logic hit_idx;
    assign hit_idx = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q[g] <= '0;
        ref_q[g] <= '0;
      end else if (hit_idx) begin
        if (wr_sel) ref_q[g] <= wr_data;
        else        ctl_q[g] <= wr_data[CW-1:0];
      end
    end
  end

endmodule

// File: rtl/dbgmp_unit.sv
module dbgmp_unit
  import dbgmp_pkg::*;
#(
  parameter int unsigned DATA_W = VAL_W
) (
  input  mp_ctl_t            ctl,
  input  logic [DATA_W-1:0]  ref_val,
  input  logic [KIND_W-1:0]  ev_kind,
  input  logic [DATA_W-1:0]  ev_value,
  output logic               hit,
  output logic               enabled,
  output logic               kind_ok,
  output logic               cond_empty
);

  logic cmp_ok;

  assign enabled    = ctl.enable;
  assign kind_ok    = filter_accepts(ctl.filter, ev_kind);
  assign cond_empty = (ctl.cond == CMP_NONE);
  assign cmp_ok     = cond_holds(ctl.cond, ctl.is_signed, ev_value, ref_val);
  assign hit        = enabled && kind_ok && cmp_ok;

endmodule

// File: rtl/dbgmp_outreg.sv
module dbgmp_outreg #(
  parameter int unsigned NUM_MP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [NUM_MP-1:0] hit_vec,
  output logic [NUM_MP-1:0] match_q,
  output logic              any_q
);

  logic [NUM_MP-1:0] gated;
  assign gated = ev_valid ? hit_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      any_q   <= 1'b0;
    end else begin
      match_q <= gated;
      any_q   <= ev_valid && (|hit_vec);
    end
  end

endmodule

// File: rtl/dbgmp_array.sv
module dbgmp_array
  import dbgmp_pkg::*;
#(
  parameter int unsigned NUM_MP = MP_COUNT,
  parameter int unsigned DATA_W = VAL_W,
  localparam int unsigned IDX_W = (NUM_MP > 1) ? $clog2(NUM_MP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [KIND_W-1:0] ev_kind,
  input  logic [DATA_W-1:0] ev_value,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_MP-1:0] match_o,
  output logic              any_match_o
);

  logic [NUM_MP-1:0][CTL_W-1:0]  ctl_q;
  logic [NUM_MP-1:0][DATA_W-1:0] ref_q;

  logic [NUM_MP-1:0] hit_vec;
  logic [NUM_MP-1:0] present_vec;
  logic [NUM_MP-1:0] class_vec;
  logic [NUM_MP-1:0] cond_none_vec;

  dbgmp_regfile #(
    .NUM_MP (NUM_MP),
    .DATA_W (DATA_W),
    .CW     (CTL_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .ctl_q   (ctl_q),
    .ref_q   (ref_q)
  );

  for (genvar g = 0; g < NUM_MP; g++) begin : g_mp
    dbgmp_unit #(
      .DATA_W (DATA_W)
    ) u_unit (
      .ctl        (mp_ctl_t'(ctl_q[g])),
      .ref_val    (ref_q[g]),
      .ev_kind    (ev_kind),
      .ev_value   (ev_value),
      .hit        (hit_vec[g]),
      .enabled    (present_vec[g]),
      .kind_ok    (class_vec[g]),
      .cond_empty (cond_none_vec[g])
    );
  end

  dbgmp_outreg #(
    .NUM_MP (NUM_MP)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (ev_valid),
    .hit_vec  (hit_vec),
    .match_q  (match_o),
    .any_q    (any_match_o)
  );

endmodule

// File: rtl/dbgmp_checker.sv
module dbgmp_checker #(
  parameter int unsigned NUM_MP = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic [NUM_MP-1:0] match_o,
  input logic              any_match_o,
  input logic [NUM_MP-1:0] present_vec,
  input logic [NUM_MP-1:0] class_vec,
  input logic [NUM_MP-1:0] cond_none_vec
);

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> (match_o == '0));

  a_r11_any_or: assert property (@(posedge clk) disable iff (!rst_n)
    any_match_o == (|match_o));

  a_r2_absent_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> ((match_o & ~$past(present_vec)) == '0));

  a_r4_class_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> ((match_o & ~$past(class_vec)) == '0));

  a_r9_nocond_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> ((match_o & $past(cond_none_vec)) == '0));

endmodule

bind dbgmp_array dbgmp_checker #(
  .NUM_MP (NUM_MP)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ev_valid      (ev_valid),
  .match_o       (match_o),
  .any_match_o   (any_match_o),
  .present_vec   (present_vec),
  .class_vec     (class_vec),
  .cond_none_vec (cond_none_vec)
);

// File: tb/sim_dbgmp_array.sv
module sim_dbgmp_array;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  typedef struct packed {
    logic [2:0]  idx;
    logic [7:0]  ctl;
    logic [31:0] refv;
    logic [2:0]  kind;
    logic [31:0] data;
    logic        exp;
  } vec_t;

  // ctl byte = filter<<5 | signed<<4 | cond<<1 | enable
  localparam vec_t TBL [NV] = '{
    '{3'd0, 8'h23, 32'h0000_1000, 3'd1, 32'h0000_1000, 1'b1}, // R3 R5 fetch equal
    '{3'd1, 8'h23, 32'h0000_1000, 3'd2, 32'h0000_1000, 1'b0}, // R3 wrong kind
    '{3'd2, 8'hC3, 32'h0000_0055, 3'd3, 32'h0000_0055, 1'b1}, // R4 ld/st addr
    '{3'd3, 8'hE3, 32'h0000_0055, 3'd2, 32'h0000_0055, 1'b0}, // R4 ld/st data vs addr
    '{3'd4, 8'h03, 32'h0000_0055, 3'd1, 32'h0000_0055, 1'b0}, // R4 filter 0
    '{3'd5, 8'h22, 32'h0000_1000, 3'd1, 32'h0000_1000, 1'b0}, // R2 disabled
    '{3'd6, 8'h85, 32'h0000_0010, 3'd4, 32'hFFFF_FFFF, 1'b0}, // R6 unsigned less
    '{3'd7, 8'h95, 32'h0000_0010, 3'd4, 32'hFFFF_FFFF, 1'b1}, // R7 signed less
    '{3'd0, 8'hAB, 32'h0000_0005, 3'd5, 32'h0000_0005, 1'b1}, // R6 unsigned ge
    '{3'd1, 8'hB9, 32'hFFFF_FFFE, 3'd5, 32'h0000_0000, 1'b1}, // R7 signed gt
    '{3'd2, 8'hA9, 32'hFFFF_FFFE, 3'd5, 32'h0000_0000, 1'b0}, // R6 unsigned gt
    '{3'd3, 8'hA7, 32'h0000_0007, 3'd5, 32'h0000_0007, 1'b1}, // R6 le equal
    '{3'd4, 8'hAD, 32'h0000_0007, 3'd5, 32'h0000_0007, 1'b0}, // R5 not equal
    '{3'd5, 8'hAF, 32'h0000_00F0, 3'd5, 32'h0000_0010, 1'b1}, // R8 mask hit
    '{3'd6, 8'hAF, 32'h0000_00F0, 3'd5, 32'h0000_000F, 1'b0}, // R8 mask miss
    '{3'd7, 8'hA1, 32'h0000_0000, 3'd5, 32'h0000_0000, 1'b0}, // R9 cond none
    '{3'd0, 8'hB7, 32'h0000_0000, 3'd5, 32'h8000_0000, 1'b1}, // R7 signed le
    '{3'd1, 8'hBB, 32'h0000_0000, 3'd5, 32'h8000_0000, 1'b0}  // R7 signed ge
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [2:0]  ev_kind = '0;
  logic [31:0] ev_value = '0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  match_o;
  logic        any_match_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgmp_array u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_valid    (ev_valid),
    .ev_kind     (ev_kind),
    .ev_value    (ev_value),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .match_o     (match_o),
    .any_match_o (any_match_o)
  );

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got any=%0b match=%08b, expected any=%0b match=%08b",
               req, got[8], got[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic wr(input logic sel, input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drives one event; returns at the negedge after the sampling edge
  task automatic fire(input logic [2:0] kind, input logic [31:0] d);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = kind; ev_value = d;
    @(negedge clk);
    ev_valid = 1'b0; ev_kind = 3'd0; ev_value = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", {any_match_o, match_o}, 9'h000);
    fire(3'd1, 32'h0);
    check("R1 reset registers give no match", {any_match_o, match_o}, 9'h000);

    for (int i = 0; i < NV; i++) begin
      if (i > 0) wr(1'b0, TBL[i-1].idx, 32'h0);
      wr(1'b1, TBL[i].idx, TBL[i].refv);
      wr(1'b0, TBL[i].idx, {24'hFFFFFF, TBL[i].ctl});
      fire(TBL[i].kind, TBL[i].data);
      check($sformatf("R10 vector %0d", i), {any_match_o, match_o},
            {TBL[i].exp, 8'(TBL[i].exp) << TBL[i].idx});
      @(negedge clk);
      check("R10 idle cycle zero", {any_match_o, match_o}, 9'h000);
    end
    wr(1'b0, TBL[NV-1].idx, 32'h0);

    // R12: each index gets its own reference; only one should fire
    for (int k = 0; k < 8; k++) begin
      wr(1'b1, 3'(k), 32'h100 + k);
      wr(1'b0, 3'(k), 32'h23);
    end
    fire(3'd1, 32'h103);
    check("R12 per-index reference", {any_match_o, match_o}, 9'h108);
    // R12: new reference on slot 5 applies to the very next event
    wr(1'b1, 3'd5, 32'h103);
    fire(3'd1, 32'h103);
    check("R12 write applies next event", {any_match_o, match_o}, 9'h128);
    // R11: all slots fire together
    for (int k = 0; k < 8; k++) wr(1'b1, 3'(k), 32'h42);
    fire(3'd1, 32'h42);
    check("R11 all fire", {any_match_o, match_o}, 9'h1FF);
    fire(3'd1, 32'h43);
    check("R11 none fire", {any_match_o, match_o}, 9'h000);

    // R1: a later reset clears the programmed registers
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    check("R1 outputs after reset", {any_match_o, match_o}, 9'h000);
    fire(3'd1, 32'h42);
    check("R1 registers cleared by reset", {any_match_o, match_o}, 9'h000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule